// File: doc/BRIEF.md
# Playback Byte Counter with Interrupt

This block follows the playback side of an audio codec. It decodes the 8-bit playback format value into a sample rate index, a crystal select, a channel count, a data format code and a byte shift. It then counts the bytes the codec accepts, one strobe per byte. When the count reaches the programmed sample count, converted to bytes, it raises a playback interrupt.

The terminal byte count is the 16-bit base count, built from an upper byte and a lower byte, shifted left by the format-dependent byte shift. Counting happens only while a transfer is being requested, which needs three things: playback is enabled, the format code is supported and the rate index is valid. When the interrupt enable is set and the terminal count is reached, the block sets both the status interrupt flag and the playback interrupt flag. It then restarts counting from zero against the same base. A clear input drops both flags.

Top module: `pb_count_irq`

## Requirements
- R1: `rate_idx_o` equals format bits [3:1] and `xtal_sel_o` equals format bit 0. `rate_valid_o` is 0 exactly when crystal 0 is selected with rate index 4 or 5.
- R2: `stereo_o` equals format bit 4.
- R3: With `mode2_i` = 1, `fmt_code_o` is format bits [7:5]. With `mode2_i` = 0 it is {0, bits [6:5]}.
- R4: Code 0 is 8-bit linear, 1 is mu-law, 3 is A-law, and 2 and 6 are 16-bit linear. Codes 4, 5 (ADPCM) and 7 set `fmt_err_o`.
- R5: `byte_shift_o` is 1 for stereo and 0 for mono with 8-bit and companded codes. It is 2 for stereo and 1 for mono with 16-bit codes.
- R6: A format value of 0x00 or 0x20 is decoded as if it were 0x30: stereo, code 1, rate index 0, crystal 0.
- R7: `dma_req_o` = play enable AND no format error AND valid rate. While it is 0, byte strobes are ignored and the byte count is held at zero.
- R8: With the interrupt enable set, the flags stay 0 after N−1 accepted strobes, where N = {upper, lower} << shift. `int_flag_o` and `pi_flag_o` are both 1 after the clock edge that accepts strobe N.
- R9: Reaching N reloads the count to zero, so the next interrupt comes after exactly N further accepted strobes.
- R10: With the interrupt enable clear, or with a base count of zero, no strobe sequence sets the flags.
- R11: `int_clr_i` clears both flags at the next edge. A terminal match in the same cycle wins over the clear.
- R12: After reset both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_reg_i | input | 8 | Playback format value |
| mode2_i | input | 1 | Selects the 3-bit format field |
| base_hi_i | input | 8 | Upper byte of base sample count |
| base_lo_i | input | 8 | Lower byte of base sample count |
| irq_en_i | input | 1 | Interrupt enable for the terminal count |
| play_en_i | input | 1 | Playback enable |
| byte_stb_i | input | 1 | One byte accepted this cycle |
| int_clr_i | input | 1 | Clear both interrupt flags |
| rate_idx_o | output | 3 | Sample rate index |
| xtal_sel_o | output | 1 | Crystal table select |
| stereo_o | output | 1 | Stereo when 1 |
| fmt_code_o | output | 3 | Decoded format code |
| byte_shift_o | output | 2 | Samples-to-bytes shift |
| rate_valid_o | output | 1 | Rate index is usable |
| fmt_err_o | output | 1 | Unsupported format code |
| dma_req_o | output | 1 | Transfer request |
| int_flag_o | output | 1 | Status interrupt flag |
| pi_flag_o | output | 1 | Playback interrupt flag |

## Verification
The decoded fields and `dma_req_o` are combinational and follow the format inputs in the same cycle. The bench therefore sweeps every format value in both field modes and reads the fields a moment after each change, with no clock edge involved. The flags are one register stage behind the strobe that completes the count or behind the clear. The bench drives each strobe or clear over one full cycle from a falling edge and reads the flags at the next falling edge, so every flag check lands one edge after its cause. The expected strobe count N is computed from the base bytes and a shift that the bench derives independently. The flags are checked both after N−1 strobes and after N strobes.

// File: rtl/pb_count_pkg.sv
package pb_count_pkg;

  typedef enum logic [2:0] {
    PB_LIN8     = 3'd0,
    PB_ULAW     = 3'd1,
    PB_LIN16_LE = 3'd2,
    PB_ALAW     = 3'd3,
    PB_RSVD_A   = 3'd4,
    PB_ADPCM    = 3'd5,
    PB_LIN16_BE = 3'd6,
    PB_RSVD_B   = 3'd7
  } pb_code_e;

  // 16-bit codes move two bytes per channel sample
  function automatic logic is_wide(pb_code_e c);
    return (c == PB_LIN16_LE) || (c == PB_LIN16_BE);
  endfunction

  function automatic logic code_supported(pb_code_e c);
    case (c)
      PB_LIN8, PB_ULAW, PB_ALAW, PB_LIN16_LE, PB_LIN16_BE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] shift_for(pb_code_e c, logic stereo);
    logic [1:0] s;
    s = {1'b0, stereo};
    if (is_wide(c)) s = s + 2'd1;
    return s;
  endfunction

  // crystal 0 has two unusable rate slots
  function automatic logic rate_usable(logic xtal, logic [2:0] idx);
    return xtal || !((idx == 3'd4) || (idx == 3'd5));
  endfunction

endpackage

// File: rtl/pb_fmt_decode.sv
module pb_fmt_decode
  import pb_count_pkg::*;
#(
  parameter int FMT_W = 8
) (
  input  logic [FMT_W-1:0] fmt_i,
  input  logic             mode2_i,
  output logic [2:0]       rate_idx_o,
  output logic             xtal_o,
  output logic             stereo_o,
  output pb_code_e         code_o,
  output logic [1:0]       shift_o,
  output logic             rate_ok_o,
  output logic             code_ok_o
);

  localparam logic [FMT_W-1:0] FORCED_FMT = FMT_W'(8'h30);
  localparam logic [FMT_W-1:0] ZERO_A     = FMT_W'(8'h00);
  localparam logic [FMT_W-1:0] ZERO_B     = FMT_W'(8'h20);

  logic [FMT_W-1:0] eff;
  logic             forced_w;

  assign forced_w = (fmt_i == ZERO_A) || (fmt_i == ZERO_B);
  assign eff      = forced_w ? FORCED_FMT : fmt_i;

  assign xtal_o     = eff[0];
  assign rate_idx_o = eff[3:1];
  assign stereo_o   = eff[4];

  always_comb begin
    if (mode2_i) code_o = pb_code_e'(eff[7:5]);
    else         code_o = pb_code_e'({1'b0, eff[6:5]});
  end

  assign shift_o   = shift_for(code_o, stereo_o);
  assign rate_ok_o = rate_usable(xtal_o, rate_idx_o);
  assign code_ok_o = code_supported(code_o);

  // R3: without the extended field the top code bit is never set
  always_comb begin
    if (!mode2_i) a_narrow_field_r3: assert (code_o[2] == 1'b0 || $isunknown(mode2_i));
  end

  // R5: a shift of two only comes with a 16-bit stereo stream
  always_comb begin
    if (shift_o == 2'd2) a_wide_shift_r5: assert ((is_wide(code_o) && stereo_o) || $isunknown(fmt_i));
  end

endmodule

// File: rtl/pb_byte_counter.sv
module pb_byte_counter #(
  parameter int HALF_W = 8,
  parameter int SHIFT_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              stb_i,
  input  logic              irq_en_i,
  input  logic [HALF_W-1:0] base_hi_i,
  input  logic [HALF_W-1:0] base_lo_i,
  input  logic [1:0]        shift_i,
  output logic              hit_o
);

  localparam int BASE_W = 2 * HALF_W;
  localparam int CNT_W  = BASE_W + SHIFT_MAX;

  function automatic logic [CNT_W-1:0] term_bytes(logic [BASE_W-1:0] b, logic [1:0] sh);
    return CNT_W'(b) << sh;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] terminal_w;
  logic [CNT_W:0]   next_w;
  logic             accept_w;

  assign terminal_w = term_bytes({base_hi_i, base_lo_i}, shift_i);
  assign accept_w   = run_i && stb_i;
  assign next_w     = {1'b0, count_q} + (CNT_W+1)'(1);
  assign hit_o      = accept_w && irq_en_i && (terminal_w != '0)
                      && (next_w == {1'b0, terminal_w});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (!run_i)   count_q <= '0;
    else if (hit_o)    count_q <= '0;
    else if (accept_w) count_q <= next_w[CNT_W-1:0];
  end

  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (count_q == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (count_q == '0));

  p_hit_needs_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (run_i && stb_i && irq_en_i));

  p_no_stb_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !stb_i) |=> $stable(count_q));

endmodule

// File: rtl/pb_irq_flags.sv
module pb_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic int_o,
  output logic pi_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_o <= 1'b0;
      pi_o  <= 1'b0;
    end else if (set_i) begin
      int_o <= 1'b1;
      pi_o  <= 1'b1;
    end else if (clr_i) begin
      int_o <= 1'b0;
      pi_o  <= 1'b0;
    end
  end

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (int_o && pi_o));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> (!int_o && !pi_o));

  p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_o && !set_i) |=> !int_o);

endmodule

// File: rtl/pb_count_irq.sv
module pb_count_irq
  import pb_count_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int FMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_reg_i,
  input  logic              mode2_i,
  input  logic [HALF_W-1:0] base_hi_i,
  input  logic [HALF_W-1:0] base_lo_i,
  input  logic              irq_en_i,
  input  logic              play_en_i,
  input  logic              byte_stb_i,
  input  logic              int_clr_i,
  output logic [2:0]        rate_idx_o,
  output logic              xtal_sel_o,
  output logic              stereo_o,
  output logic [2:0]        fmt_code_o,
  output logic [1:0]        byte_shift_o,
  output logic              rate_valid_o,
  output logic              fmt_err_o,
  output logic              dma_req_o,
  output logic              int_flag_o,
  output logic              pi_flag_o
);

  localparam int SHIFT_MAX = 2;

  pb_code_e code_w;
  logic     code_ok_w;
  logic     hit_w;

  pb_fmt_decode #(.FMT_W(FMT_W)) u_dec (
    .fmt_i      (fmt_reg_i),
    .mode2_i    (mode2_i),
    .rate_idx_o (rate_idx_o),
    .xtal_o     (xtal_sel_o),
    .stereo_o   (stereo_o),
    .code_o     (code_w),
    .shift_o    (byte_shift_o),
    .rate_ok_o  (rate_valid_o),
    .code_ok_o  (code_ok_w)
  );

  assign fmt_code_o = code_w;
  assign fmt_err_o  = !code_ok_w;
  assign dma_req_o  = play_en_i && code_ok_w && rate_valid_o;

  pb_byte_counter #(.HALF_W(HALF_W), .SHIFT_MAX(SHIFT_MAX)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (dma_req_o),
    .stb_i     (byte_stb_i),
    .irq_en_i  (irq_en_i),
    .base_hi_i (base_hi_i),
    .base_lo_i (base_lo_i),
    .shift_i   (byte_shift_o),
    .hit_o     (hit_w)
  );

  pb_irq_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hit_w),
    .clr_i (int_clr_i),
    .int_o (int_flag_o),
    .pi_o  (pi_flag_o)
  );

  p_err_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err_o |-> !dma_req_o);

  p_req_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> play_en_i);

  p_bad_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_valid_o |-> (!xtal_sel_o && !dma_req_o));

endmodule

// File: tb/tb_pb_count_irq.sv
`timescale 1ns/1ps
module tb_pb_count_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fmt = 8'h00;
  logic       mode2 = 1'b0;
  logic [7:0] bhi = 8'h00, blo = 8'h00;
  logic       irq_en = 1'b0, play_en = 1'b0, stb = 1'b0, clr = 1'b0;
  logic [2:0] rate_idx, code;
  logic       xtal, stereo, rate_valid, fmt_err, dma_req, int_f, pi_f;
  logic [1:0] shift;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pb_count_irq dut (
    .clk(clk), .rst_n(rst_n), .fmt_reg_i(fmt), .mode2_i(mode2),
    .base_hi_i(bhi), .base_lo_i(blo), .irq_en_i(irq_en), .play_en_i(play_en),
    .byte_stb_i(stb), .int_clr_i(clr), .rate_idx_o(rate_idx), .xtal_sel_o(xtal),
    .stereo_o(stereo), .fmt_code_o(code), .byte_shift_o(shift),
    .rate_valid_o(rate_valid), .fmt_err_o(fmt_err), .dma_req_o(dma_req),
    .int_flag_o(int_f), .pi_flag_o(pi_f)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_shift(int f, bit m2);
    int v, c, st;
    v  = (f == 0 || f == 32) ? 48 : f;
    st = (v / 16) % 2;
    c  = m2 ? (v / 32) % 8 : (v / 32) % 4;
    return (c == 2 || c == 6) ? st + 1 : st;
  endfunction

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      if (i % 4 == 3) @(negedge clk);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic setup(int f, bit m2, int base);
    play_en = 1'b0;
    fmt = f[7:0]; mode2 = m2;
    bhi = base[15:8]; blo = base[7:0];
    irq_en = 1'b1;
    @(negedge clk);
    do_clear();
    play_en = 1'b1;
  endtask

  task automatic terminal_run(int f, bit m2, int base);
    int n;
    setup(f, m2, base);
    n = base << exp_shift(f, m2);
    pulse(n - 1);
    check("R8 flag before N", int_f, 0);
    pulse(1);
    check("R8 int at N", int_f, 1);
    check("R8 pi at N", pi_f, 1);
    do_clear();
    check("R11 int cleared", int_f, 0);
    check("R11 pi cleared", pi_f, 0);
    pulse(n - 1);
    check("R9 flag before second N", int_f, 0);
    pulse(1);
    check("R9 flag at second N", int_f, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 int after reset", int_f, 0);
    check("R12 pi after reset", pi_f, 0);

    // full decode sweep
    play_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 256; f++) begin
        int v, xt, idx, st, c, er, rv;
        mode2 = m[0];
        fmt = f[7:0];
        #1;
        v   = (f == 0 || f == 32) ? 48 : f;
        xt  = v % 2;
        idx = (v / 2) % 8;
        st  = (v / 16) % 2;
        c   = m ? (v / 32) % 8 : (v / 32) % 4;
        er  = (c == 4 || c == 5 || c == 7) ? 1 : 0;
        rv  = (xt == 0 && (idx == 4 || idx == 5)) ? 0 : 1;
        if (f == 0 || f == 32) check("R6 forced code", code, 1);
        check("R1 rate index", rate_idx, idx);
        check("R1 crystal", xtal, xt);
        check("R1 rate valid", rate_valid, rv);
        check("R2 stereo", stereo, st);
        check("R3 field", code, c);
        check("R4 error", fmt_err, er);
        check("R5 shift", shift, exp_shift(f, m[0]));
        check("R7 request", dma_req, (er == 0 && rv == 1) ? 1 : 0);
      end
    end
    play_en = 1'b0;
    #1;
    check("R7 request off", dma_req, 0);
    @(negedge clk);

    terminal_run(8'h00, 1'b0, 3);
    terminal_run(8'h01, 1'b0, 5);
    terminal_run(8'h40, 1'b0, 4);
    terminal_run(8'h50, 1'b1, 3);
    terminal_run(8'hD1, 1'b1, 2);
    terminal_run(8'h61, 1'b0, 256);

    // R10: interrupt enable clear
    setup(8'h01, 1'b0, 3);
    irq_en = 1'b0;
    pulse(9);
    check("R10 no flag irq_en off", int_f, 0);
    // R10: zero base
    setup(8'h01, 1'b0, 0);
    pulse(20);
    check("R10 no flag zero base", int_f, 0);

    // R7: dropping play enable restarts the count
    setup(8'h01, 1'b0, 4);
    pulse(3);
    play_en = 1'b0;
    @(negedge clk);
    play_en = 1'b1;
    pulse(1);
    check("R7 count restarted", int_f, 0);
    pulse(3);
    check("R7 full count after restart", int_f, 1);

    // R7: unsupported code ignores strobes
    setup(8'hA1, 1'b1, 1);
    pulse(6);
    check("R7 adpcm ignores strobes", int_f, 0);
    fmt = 8'h01;
    pulse(1);
    check("R7 supported after switch", int_f, 1);

    // R11: match in the clear cycle wins
    setup(8'h01, 1'b0, 2);
    pulse(1);
    clr = 1'b1;
    stb = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    stb = 1'b0;
    check("R11 set wins over clear", int_f, 1);
    do_clear();
    check("R11 plain clear", pi_f, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule